// File: doc/BRIEF.md
# Line Buffer Pool with Per-Word Valid Bits

This block is a shared pool of staging buffers. Each buffer holds one cache line, split into fixed-width words. A producer takes a free buffer, then writes the words of one message into it. Every word has its own valid flag, which the write sets. A consumer names the same buffer and a word index. It may take that word as soon as the word's flag is set, even while later words of the line are still arriving. This lets data stream straight from the source port to the destination port, with no second copy.

Control logic never moves the data. It passes around only the buffer number, and the data stays in place until it has been delivered. After delivery, the buffer is handed back to the pool. Handing a buffer back wipes all of its valid flags, so its next user starts from an empty line. Allocation always gives out the lowest-numbered free buffer, and a separate flag reports when no buffer is free.

Top module: `lbuf_pool`

## Requirements
- R1: After reset, every buffer is free and no word is valid: `alloc_id` is 0, `pool_empty` is 0, and `rd_ready` is 0 for any read.
- R2: `alloc_id` always shows the lowest-numbered free buffer. When `alloc_req` is high at a clock edge and the pool is not empty, that buffer becomes taken.
- R3: `pool_empty` is high exactly when all `NBUF` buffers are taken. An `alloc_req` while the pool is empty changes nothing.
- R4: A write with `wr_en` high stores `wr_data` and sets the valid flag of word `wr_word` in buffer `wr_id`. `rd_ready` for that word is high from the next cycle on.
- R5: `rd_ready` is 0 whenever `rd_en` is 0, and whenever the addressed word's valid flag is clear. It stays 0 until that word is written.
- R6: When a write and a read address the same word in the same cycle, `rd_ready` is 0 in that cycle. In the following cycle, `rd_ready` is 1 and the word can be read.
- R7: While `rd_ready` is 1, `rd_data` equals the last value written to that buffer and word, and data is selected only by buffer number and word index.
- R8: When `free_req` is high at a clock edge, buffer `free_id` returns to the pool and all of its valid flags clear. A write to that buffer in the same cycle is discarded.
- R9: Writing or freeing one buffer does not change the valid flags or data of any other buffer.
- R10: A word that has been written reads as ready while a higher word of the same buffer is still not valid. The line does not need to be complete first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_req | input | 1 | Take the buffer shown on `alloc_id` |
| alloc_id | output | log2(NBUF) | Lowest free buffer number |
| pool_empty | output | 1 | No buffer is free |
| free_req | input | 1 | Return buffer `free_id` to the pool |
| free_id | input | log2(NBUF) | Buffer to return |
| wr_en | input | 1 | Write one word |
| wr_id | input | log2(NBUF) | Buffer being written |
| wr_word | input | log2(WORDS) | Word index being written |
| wr_data | input | DW | Write data |
| rd_en | input | 1 | Read request |
| rd_id | input | log2(NBUF) | Buffer being read |
| rd_word | input | log2(WORDS) | Word index being read |
| rd_data | output | DW | Read data for the addressed word |
| rd_ready | output | 1 | Addressed word is valid and may be consumed |

## Verification
The properties assume the following about the inputs:
- Writes target only buffers that have been allocated.
- Free requests name only taken buffers.
- No buffer is allocated and freed in the same cycle.

The stimulus keeps to this by design. It allocates the whole pool before any write. It frees only buffers it has taken. It re-allocates a freed buffer only in a later cycle. Each word is written in ascending order with a distinct, arithmetically derived value. This means a stale or misrouted read shows up as a data mismatch.

// File: rtl/lbuf_pool.sv
module lbuf_pool #(
  parameter int NBUF  = 16,
  parameter int WORDS = 16,
  parameter int DW    = 64,
  localparam int IW   = $clog2(NBUF),
  localparam int WW   = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc_req,
  output logic [IW-1:0] alloc_id,
  output logic          pool_empty,
  input  logic          free_req,
  input  logic [IW-1:0] free_id,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_id,
  input  logic [WW-1:0] wr_word,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic [IW-1:0] rd_id,
  input  logic [WW-1:0] rd_word,
  output logic [DW-1:0] rd_data,
  output logic          rd_ready
);
  localparam int CELLS = NBUF * WORDS;

  logic [DW-1:0]    store [CELLS];
  logic [CELLS-1:0] vld;
  logic [NBUF-1:0]  busy;

  wire [IW+WW-1:0] wa = {wr_id, wr_word};
  wire [IW+WW-1:0] ra = {rd_id, rd_word};
  wire wr_keep = wr_en && !(free_req && free_id == wr_id);

  always_comb begin
    alloc_id = '0;
    for (int i = NBUF - 1; i >= 0; i--)
      if (!busy[i]) alloc_id = IW'(i);
  end

  assign pool_empty = &busy;
  assign rd_data    = store[ra];
  assign rd_ready   = rd_en && vld[ra];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= '0;
    end else begin
      if (alloc_req && !pool_empty) busy[alloc_id] <= 1'b1;
      if (free_req) busy[free_id] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld <= '0;
    end else begin
      if (wr_keep) vld[wa] <= 1'b1;
      if (free_req)
        for (int w = 0; w < WORDS; w++) vld[{free_id, WW'(w)}] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_keep) store[wa] <= wr_data;
  end
endmodule

// File: rtl/lbuf_pool_chk.sv
module lbuf_pool_chk #(
  parameter int NBUF  = 16,
  parameter int WORDS = 16,
  parameter int DW    = 64,
  localparam int IW   = $clog2(NBUF),
  localparam int WW   = $clog2(WORDS)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          alloc_req,
  input logic [IW-1:0] alloc_id,
  input logic          pool_empty,
  input logic          free_req,
  input logic [IW-1:0] free_id,
  input logic          wr_en,
  input logic [IW-1:0] wr_id,
  input logic [WW-1:0] wr_word,
  input logic [DW-1:0] wr_data,
  input logic          rd_en,
  input logic [IW-1:0] rd_id,
  input logic [WW-1:0] rd_word,
  input logic [DW-1:0] rd_data,
  input logic          rd_ready
);
  wire same_word = wr_en && rd_en && wr_id == rd_id && wr_word == rd_word &&
                   !(free_req && free_id == wr_id);

  assert_grant_moves_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_req && !pool_empty && !free_req) |=> (alloc_id != $past(alloc_id) || pool_empty));

  assert_empty_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pool_empty && !free_req) |=> pool_empty);

  assert_written_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
    same_word |=> (!(rd_en && $stable(rd_id) && $stable(rd_word)) || rd_ready));

  assert_read_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
    same_word |=> (!(rd_en && $stable(rd_id) && $stable(rd_word)) || rd_data == $past(wr_data)));

  assert_free_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    free_req |=> !(rd_en && rd_id == $past(free_id) && rd_ready));

  assert_idle_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> !rd_ready);
endmodule

bind lbuf_pool lbuf_pool_chk #(.NBUF(NBUF), .WORDS(WORDS), .DW(DW)) u_chk (.*);

// File: tb/sim_lbuf_pool.sv
module sim_lbuf_pool;
  localparam int CLK_PERIOD = 10;
  localparam int NBUF = 16, WORDS = 16, DW = 64;
  localparam int IW = $clog2(NBUF), WW = $clog2(WORDS);

  logic clk = 0, rst_n = 0;
  logic alloc_req, free_req, wr_en, rd_en;
  logic [IW-1:0] free_id, wr_id, rd_id, alloc_id;
  logic [WW-1:0] wr_word, rd_word;
  logic [DW-1:0] wr_data, rd_data;
  logic pool_empty, rd_ready;
  int nchk = 0, nerr = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lbuf_pool #(.NBUF(NBUF), .WORDS(WORDS), .DW(DW)) u0 (.*);

  function automatic logic [DW-1:0] pat(int b, int w);
    return ((64'(b) * 64'h1000 + 64'(w) + 1) * 64'h9E3779B97F4A7C15) ^ 64'h0F0F_A5A5_3C3C_5A5A;
  endfunction

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    alloc_req = 0; free_req = 0; free_id = '0; wr_en = 0; wr_id = '0;
    wr_word = '0; wr_data = '0; rd_en = 0; rd_id = '0; rd_word = '0;
  endtask

  task automatic rd(int b, int w);
    rd_en = 1; rd_id = IW'(b); rd_word = WW'(w); #1;
  endtask

  initial begin
    idle();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    #1;
    chk("R1 alloc_id", 64'(alloc_id), 0);
    chk("R1 pool_empty", 64'(pool_empty), 0);
    rd(0, 0);
    chk("R1 rd_ready", 64'(rd_ready), 0);

    for (int i = 0; i < NBUF; i++) begin
      @(negedge clk) idle(); alloc_req = 1; #1;
      chk("R2 lowest free", 64'(alloc_id), 64'(i));
      chk("R3 not empty", 64'(pool_empty), 0);
    end
    @(negedge clk) idle(); #1;
    chk("R3 empty when all taken", 64'(pool_empty), 1);
    @(negedge clk) alloc_req = 1;
    @(negedge clk) idle(); #1;
    chk("R3 alloc while empty", 64'(pool_empty), 1);
    @(negedge clk) free_req = 1; free_id = IW'(5);
    @(negedge clk) idle(); #1;
    chk("R8 freed returns", 64'(alloc_id), 5);
    chk("R8 not empty", 64'(pool_empty), 0);
    @(negedge clk) alloc_req = 1;
    @(negedge clk) idle(); #1;
    chk("R2 retaken", 64'(pool_empty), 1);

    for (int b = 0; b < NBUF; b++) begin
      for (int w = 0; w < WORDS; w++) begin
        @(negedge clk) idle();
        wr_en = 1; wr_id = IW'(b); wr_word = WW'(w); wr_data = pat(b, w);
        rd(b, w);
        chk("R6 same-cycle stall", 64'(rd_ready), 0);
        @(negedge clk) idle();
        rd(b, w);
        chk("R4 ready after write", 64'(rd_ready), 1);
        chk("R7 data", rd_data, pat(b, w));
        if (w < WORDS - 1) begin
          rd(b, w + 1);
          chk("R10 later word not valid", 64'(rd_ready), 0);
          rd(b, 0);
          chk("R10 earlier word ready", 64'(rd_ready), 1);
        end
        if (b < NBUF - 1) begin
          rd(b + 1, w);
          chk("R9 other buffer untouched", 64'(rd_ready), 0);
        end
      end
    end

    for (int b = NBUF - 1; b >= 0; b--)
      for (int w = WORDS - 1; w >= 0; w--) begin
        @(negedge clk) idle();
        rd(b, w);
        chk("R7 readback ready", 64'(rd_ready), 1);
        chk("R7 readback data", rd_data, pat(b, w));
      end

    @(negedge clk) idle(); #1;
    chk("R5 no request", 64'(rd_ready), 0);

    @(negedge clk) idle();
    free_req = 1; free_id = IW'(3);
    wr_en = 1; wr_id = IW'(3); wr_word = '0; wr_data = '1;
    @(negedge clk) idle(); #1;
    chk("R8 alloc_id after free", 64'(alloc_id), 3);
    for (int w = 0; w < WORDS; w++) begin
      rd(3, w);
      chk("R8 valid cleared", 64'(rd_ready), 0);
    end
    @(negedge clk) idle();
    rd(4, 0);
    chk("R9 neighbour ready", 64'(rd_ready), 1);
    chk("R9 neighbour data", rd_data, pat(4, 0));
    rd(2, 15);
    chk("R9 neighbour data", rd_data, pat(2, 15));

    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule